// File: doc/BRIEF.md
# Bootstrap Status and Write-Once Configuration Register Block

This block holds two 32-bit memory-mapped registers that describe how the device came up. The status register latches the external bootstrap pins on power-on reset. Those values then survive every other kind of reset. Software may later adjust some of its fields, but the endian flag always keeps the value that was captured.

The configuration register returns to its default value on every hard reset. Power-on reset also counts as a hard reset. Software gets exactly one write to the configuration register: that write locks it, and the lock holds until the next hard reset. Each field of both registers is also brought out on a port of its own, so that neighbouring logic can use it directly.

Access goes through a single-cycle bus with a word address, a write strobe and write data. Read data is registered and appears one clock after the address is presented.

Top module: `boot_cfg_regs`

## Requirements
- R1: When por_i is high at a rising clock edge, status bits 19:0 load from strap_i[19:0] and bits 31:20 become 0.
- R2: A hard reset (hrst_i high, por_i low) leaves every status bit unchanged, including any value written by software.
- R3: A write to word address 0 (status) updates bits 19:1 from wdata_i[19:1]; bit 0 (the endian flag, 1 = little endian) keeps its captured value.
- R4: Status bits 31:20 always read as 0, even after ones are written there.
- R5: On por_i or hrst_i the configuration register becomes 0x00000001 and the lock clears (cfg_locked_o = 0).
- R6: The first write to word address 1 (configuration) while unlocked stores wdata_i[4:0], with bits 31:5 reading 0, and sets the lock, even when the data equals the current value.
- R7: While locked, writes to the configuration register change nothing until the next hard reset.
- R8: rdata_o is registered: one cycle after addr_i is presented it shows status for address 0, configuration for address 1, and 0 for any other address. After a cycle in which any reset is high it shows 0.
- R9: Writes to unmapped addresses change no register, and writes during any reset are ignored.
- R10: The field ports mirror the registers. endian_o is status bit 0, bootmode_o is 16:1, vsif_sel_o is 18:17 and pll_div_sel_o is 19. clkout_en_o is config bit 0, pcie0_mode_o is 2:1 and pcie1_mode_o is 4:3 (00 endpoint, 01 legacy endpoint, 10 root complex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| hrst_i | input | 1 | Hard reset, synchronous, active high |
| strap_i | input | 20 | Bootstrap pin values |
| addr_i | input | 4 | Word address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| endian_o | output | 1 | Endian flag (1 = little) |
| bootmode_o | output | 16 | Boot mode field |
| vsif_sel_o | output | 2 | Voltage-scaling interface select |
| pll_div_sel_o | output | 1 | Main PLL output divider select |
| clkout_en_o | output | 1 | System clock output enable |
| pcie0_mode_o | output | 2 | PCIe port 0 mode |
| pcie1_mode_o | output | 2 | PCIe port 1 mode |
| cfg_locked_o | output | 1 | Configuration write lock state |

## Verification
The assertions check on every cycle the relations that hold whatever the data: reset capture of the straps, status stability across a hard reset, the configuration default and lock clear, the lock being set by the first write and holding afterwards, and zero read data for reserved bits, unmapped addresses and reset cycles. Only the bench scenarios can show the actual stored values. These include the per-bit masking of status writes around the read-only endian flag, the truncation of configuration writes to five bits, a same-value write that still locks, and re-capture of a different strap pattern on a second power-on reset.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
  localparam int DATA_W    = 32;
  localparam int STRAP_W   = 20;
  // status field positions
  localparam int ENDIAN_BIT = 0;
  localparam int BOOT_LSB   = 1;
  localparam int BOOT_W     = 16;
  localparam int VSIF_LSB   = 17;
  localparam int VSIF_W     = 2;
  localparam int PLLD_BIT   = 19;
  // configuration field positions
  localparam int CLKO_BIT   = 0;
  localparam int PCIE0_LSB  = 1;
  localparam int PCIE1_LSB  = 3;
  localparam int PCIE_W     = 2;
  localparam int CFG_FW     = 5;
  localparam logic [DATA_W-1:0] CFG_RST = 32'h0000_0001;

  typedef enum logic [1:0] {
    PCIE_EP     = 2'b00,
    PCIE_LEG_EP = 2'b01,
    PCIE_RC     = 2'b10,
    PCIE_RSVD   = 2'b11
  } pcie_mode_e;
endpackage

// File: rtl/strap_status_reg.sv
module strap_status_reg #(
  parameter int DW      = 32,
  parameter int SW      = 20,
  parameter int RO_BITS = 1
) (
  input  logic          clk,
  input  logic          por,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] strap,
  output logic [DW-1:0] q
);
  // Per-bit structure: reserved bits tie to 0, the low RO_BITS only
  // load on power-on, the rest load on power-on or on a software write.
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i >= SW) begin : g_rsvd
      assign q[i] = 1'b0;
    end else if (i < RO_BITS) begin : g_ro
      always_ff @(posedge clk) begin
        if (por) q[i] <= strap[i];
      end
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (por)        q[i] <= strap[i];
        else if (wr_en) q[i] <= wdata[i];
      end
    end
  end
endmodule

// File: rtl/wo_config_reg.sv
module wo_config_reg #(
  parameter int          DW      = 32,
  parameter int          FW      = 5,
  parameter logic [31:0] RST_VAL = 32'h1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q,
  output logic          locked
);
  logic [FW-1:0] fld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q  <= RST_VAL[FW-1:0];
      locked <= 1'b0;
    end else if (wr_en && !locked) begin
      fld_q  <= wdata[FW-1:0];
      locked <= 1'b1;
    end
  end

  assign q = {{(DW-FW){1'b0}}, fld_q};
endmodule

// File: rtl/reg_read_mux.sv
module reg_read_mux #(
  parameter int DW        = 32,
  parameter int AW        = 4,
  parameter int STAT_ADDR = 0,
  parameter int CFG_ADDR  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] stat,
  input  logic [DW-1:0] cfg,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] sel_d;

  always_comb begin
    if (addr == AW'(STAT_ADDR))     sel_d = stat;
    else if (addr == AW'(CFG_ADDR)) sel_d = cfg;
    else                            sel_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel_d;
  end
endmodule

// File: rtl/boot_cfg_regs.sv
module boot_cfg_regs
  import boot_cfg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int CFG_ADDR  = 1
) (
  input  logic                clk,
  input  logic                por_i,
  input  logic                hrst_i,
  input  logic [STRAP_W-1:0]  strap_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                endian_o,
  output logic [BOOT_W-1:0]   bootmode_o,
  output logic [VSIF_W-1:0]   vsif_sel_o,
  output logic                pll_div_sel_o,
  output logic                clkout_en_o,
  output logic [PCIE_W-1:0]   pcie0_mode_o,
  output logic [PCIE_W-1:0]   pcie1_mode_o,
  output logic                cfg_locked_o
);
  logic              any_rst;
  logic              wr_ok;
  logic              stat_we;
  logic              cfg_we;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] cfg_q;

  assign any_rst = por_i | hrst_i;
  assign wr_ok   = wr_en_i & ~any_rst;
  assign stat_we = wr_ok & (addr_i == ADDR_W'(STAT_ADDR));
  assign cfg_we  = wr_ok & (addr_i == ADDR_W'(CFG_ADDR));

  strap_status_reg #(
    .DW(DATA_W), .SW(STRAP_W), .RO_BITS(ENDIAN_BIT + 1)
  ) u_stat (
    .clk(clk), .por(por_i), .wr_en(stat_we),
    .wdata(wdata_i), .strap(strap_i), .q(stat_q)
  );

  wo_config_reg #(
    .DW(DATA_W), .FW(CFG_FW), .RST_VAL(CFG_RST)
  ) u_cfg (
    .clk(clk), .rst(any_rst), .wr_en(cfg_we),
    .wdata(wdata_i), .q(cfg_q), .locked(cfg_locked_o)
  );

  reg_read_mux #(
    .DW(DATA_W), .AW(ADDR_W), .STAT_ADDR(STAT_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_rd (
    .clk(clk), .rst(any_rst), .addr(addr_i),
    .stat(stat_q), .cfg(cfg_q), .rdata(rdata_o)
  );

  assign endian_o      = stat_q[ENDIAN_BIT];
  assign bootmode_o    = stat_q[BOOT_LSB +: BOOT_W];
  assign vsif_sel_o    = stat_q[VSIF_LSB +: VSIF_W];
  assign pll_div_sel_o = stat_q[PLLD_BIT];
  assign clkout_en_o   = cfg_q[CLKO_BIT];
  assign pcie0_mode_o  = cfg_q[PCIE0_LSB +: PCIE_W];
  assign pcie1_mode_o  = cfg_q[PCIE1_LSB +: PCIE_W];
endmodule

// File: rtl/boot_cfg_chk.sv
module boot_cfg_chk #(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int CFG_ADDR  = 1
) (
  input logic              clk,
  input logic              por_i,
  input logic              hrst_i,
  input logic [19:0]       strap_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       rdata_o,
  input logic              endian_o,
  input logic [15:0]       bootmode_o,
  input logic [1:0]        vsif_sel_o,
  input logic              pll_div_sel_o,
  input logic              clkout_en_o,
  input logic [1:0]        pcie0_mode_o,
  input logic [1:0]        pcie1_mode_o,
  input logic              cfg_locked_o
);
  logic seen_por = 1'b0;
  always_ff @(posedge clk) if (por_i) seen_por <= 1'b1;

  assert_strap_capture_R1: assert property (@(posedge clk) disable iff (!seen_por)
    por_i |=> {pll_div_sel_o, vsif_sel_o, bootmode_o, endian_o} == $past(strap_i));

  assert_status_keep_R2: assert property (@(posedge clk) disable iff (!seen_por || por_i)
    (hrst_i && !por_i) |=> ($stable(endian_o) && $stable(bootmode_o) &&
                            $stable(vsif_sel_o) && $stable(pll_div_sel_o)));

  assert_stat_rsvd_R4: assert property (@(posedge clk) disable iff (!seen_por)
    (addr_i == ADDR_W'(STAT_ADDR)) |=> rdata_o[31:20] == 12'h0);

  assert_cfg_default_R5: assert property (@(posedge clk) disable iff (!seen_por)
    (por_i || hrst_i) |=> (clkout_en_o && pcie0_mode_o == 2'b00 &&
                           pcie1_mode_o == 2'b00 && !cfg_locked_o));

  assert_first_write_locks_R6: assert property (@(posedge clk)
    disable iff (!seen_por || por_i || hrst_i)
    (wr_en_i && addr_i == ADDR_W'(CFG_ADDR) && !cfg_locked_o) |=> cfg_locked_o);

  assert_lock_holds_R7: assert property (@(posedge clk)
    disable iff (!seen_por || por_i || hrst_i)
    cfg_locked_o |=> (cfg_locked_o && $stable(clkout_en_o) &&
                      $stable(pcie0_mode_o) && $stable(pcie1_mode_o)));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!seen_por)
    (addr_i != ADDR_W'(STAT_ADDR) && addr_i != ADDR_W'(CFG_ADDR)) |=> rdata_o == 32'h0);

  assert_reset_rdata_R8: assert property (@(posedge clk) disable iff (!seen_por)
    (por_i || hrst_i) |=> rdata_o == 32'h0);
endmodule

bind boot_cfg_regs boot_cfg_chk #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CFG_ADDR(CFG_ADDR)
) u_chk (
  .clk(clk), .por_i(por_i), .hrst_i(hrst_i), .strap_i(strap_i),
  .addr_i(addr_i), .wr_en_i(wr_en_i), .rdata_o(rdata_o),
  .endian_o(endian_o), .bootmode_o(bootmode_o), .vsif_sel_o(vsif_sel_o),
  .pll_div_sel_o(pll_div_sel_o), .clkout_en_o(clkout_en_o),
  .pcie0_mode_o(pcie0_mode_o), .pcie1_mode_o(pcie1_mode_o),
  .cfg_locked_o(cfg_locked_o)
);

// File: tb/tb_boot_cfg_regs.sv
`timescale 1ns/1ps
module tb_boot_cfg_regs;
  logic        clk = 1'b0;
  logic        por_i = 1'b1, hrst_i = 1'b0, wr_en_i = 1'b0;
  logic [19:0] strap_i;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        endian_o, pll_div_sel_o, clkout_en_o, cfg_locked_o;
  logic [15:0] bootmode_o;
  logic [1:0]  vsif_sel_o, pcie0_mode_o, pcie1_mode_o;

  localparam logic [19:0] S0 = 20'h3_1235;
  localparam logic [19:0] S1 = 20'hC_0002;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  boot_cfg_regs dut (
    .clk(clk), .por_i(por_i), .hrst_i(hrst_i), .strap_i(strap_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .endian_o(endian_o), .bootmode_o(bootmode_o), .vsif_sel_o(vsif_sel_o),
    .pll_div_sel_o(pll_div_sel_o), .clkout_en_o(clkout_en_o),
    .pcie0_mode_o(pcie0_mode_o), .pcie1_mode_o(pcie1_mode_o),
    .cfg_locked_o(cfg_locked_o)
  );

  // entry: {do_wr, waddr, wdata, raddr, expected}
  localparam int NV = 9;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 4'd0, 32'h0,         4'd0, 32'h0003_1235}, // R1 captured straps
    {1'b0, 4'd0, 32'h0,         4'd1, 32'h0000_0001}, // R5 config default
    {1'b0, 4'd0, 32'h0,         4'd5, 32'h0000_0000}, // R8 unmapped read
    {1'b1, 4'd0, 32'hFFFF_FFFE, 4'd0, 32'h000F_FFFF}, // R3 R4 endian kept, rsvd 0
    {1'b1, 4'd0, 32'h0000_0000, 4'd0, 32'h0000_0001}, // R3 endian still 1
    {1'b1, 4'd7, 32'hFFFF_FFFF, 4'd0, 32'h0000_0001}, // R9 status untouched
    {1'b0, 4'd0, 32'h0,         4'd1, 32'h0000_0001}, // R9 config untouched
    {1'b1, 4'd1, 32'hFFFF_FFF6, 4'd1, 32'h0000_0016}, // R6 first write masked
    {1'b1, 4'd1, 32'h0000_000B, 4'd1, 32'h0000_0016}  // R7 locked write ignored
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a; wr_en_i = 1'b0;
    @(negedge clk);
    d = rdata_o;
  endtask

  task automatic pulse(input bit p, input bit h);
    @(negedge clk);
    por_i = p; hrst_i = h;
    @(negedge clk);
    por_i = 1'b0; hrst_i = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    strap_i = S0;
    repeat (3) @(negedge clk);
    por_i = 1'b0;
    @(negedge clk);
    // reset state
    check("R5 lock clear after por", {31'b0, cfg_locked_o}, 32'h0);
    check("R10 status fields", {12'b0, pll_div_sel_o, vsif_sel_o, bootmode_o, endian_o},
          {12'b0, S0});

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:68], VEC[i][67:36]);
      rd(VEC[i][35:32], v);
      check($sformatf("vector %0d", i), v, VEC[i][31:0]);
    end
    check("R6 lock set", {31'b0, cfg_locked_o}, 32'h1);
    // config 0x16 -> clkout 0, pcie0 11, pcie1 10
    check("R10 config fields", {27'b0, pcie1_mode_o, pcie0_mode_o, clkout_en_o}, 32'h16);

    // hard reset with new straps
    strap_i = S1;
    pulse(1'b0, 1'b1);
    check("R5 lock clear after hrst", {31'b0, cfg_locked_o}, 32'h0);
    rd(4'd0, v); check("R2 status survives hrst", v, 32'h1);
    rd(4'd1, v); check("R5 config default after hrst", v, 32'h1);
    wr(4'd1, 32'h1);
    check("R6 same-value write locks", {31'b0, cfg_locked_o}, 32'h1);
    wr(4'd1, 32'h1E);
    rd(4'd1, v); check("R7 write after lock ignored", v, 32'h1);

    // write during reset is ignored
    @(negedge clk);
    hrst_i = 1'b1; addr_i = 4'd0; wdata_i = 32'h0; wr_en_i = 1'b1;
    @(negedge clk);
    check("R8 rdata zero in reset", rdata_o, 32'h0);
    hrst_i = 1'b0; wr_en_i = 1'b0;
    rd(4'd0, v); check("R9 status write in reset ignored", v, 32'h1);

    // second power-on reset recaptures straps
    pulse(1'b1, 1'b0);
    rd(4'd0, v); check("R1 recapture", v, {12'b0, S1});
    check("R10 endian big", {31'b0, endian_o}, {31'b0, S1[0]});
    check("R10 bootmode", {16'b0, bootmode_o}, {16'b0, S1[16:1]});
    check("R10 vsif/pll", {29'b0, pll_div_sel_o, vsif_sel_o}, {29'b0, S1[19:17]});
    rd(4'd1, v); check("R5 config default after por", v, 32'h1);
    check("R5 unlocked after por", {31'b0, cfg_locked_o}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule